// File: doc/BRIEF.md
# Delayed Transaction Discard Timer

This block sits beside a bridge's queue of completed delayed transactions and watches the entry at the head of that queue. The timer starts only when a completion reaches the head, not when it is first queued. From then on it counts bus clocks until the master that issued the request comes back with a matching retry. A matching retry stops the timer, and the completion is then delivered in the normal way. If no retry arrives in time, the block emits a one-cycle discard pulse carrying the entry's ID, so the queue can drop it. It also sets a sticky status flag and, when enabled, pulses an error line toward the primary side.

Two timeout ranges can be selected. The long range expires after 2^LONG_EXP clocks and the short range after 2^SHORT_EXP clocks. The defaults are 15 and 10, which give 32768 and 1024 clocks. Both figures sit inside the power-of-two windows [2^15, 2^16] and [2^10, 2^11]. A small configuration port holds the range select, the error enable and the write-one-to-clear status bit.

The head port is an observation-only stream. The block never stalls the queue, so the port has no ready signal. The discard pulse has no back-pressure: the queue must act on it in the cycle it is high and pop the entry on the following edge. The configuration pins are plain control and status signals.

Top module: `dtd_discard_timer`

## Requirements
- R1: After reset, cfg_rdata is 0 (long range, error disabled, status clear) and disc_valid and err_pulse are low.
- R2: With cfg bit 0 at 0, an entry held at the head with no retry makes disc_valid high in the cycle after rising edge number 2^LONG_EXP+1. Edge 1 is the first edge that samples head_valid high with that head_id.
- R3: With cfg bit 0 at 1, the same discard happens after rising edge number 2^SHORT_EXP+1.
- R4: Counting edges as in R2, if retry_hit is sampled high on any edge numbered 1 to 2^E (E being the selected exponent), the entry is not discarded for as long as it stays at the head with the same ID.
- R5: A retry_hit sampled on the expiry edge itself (edge 2^E+1) is too late: the discard still happens.
- R6: disc_valid is high for exactly one cycle and disc_id equals the discarded entry's ID. The head is ignored during the pulse cycle. If an entry is still at the head afterwards, it is timed as a new entry, so the next discard of a held head follows 2^E+2 edges after the previous one.
- R7: A change of head_id, or head_valid going low, restarts the timer. The new entry's edge 1 is the first edge that samples it.
- R8: Status (cfg bit 2) becomes 1 on the edge that raises disc_valid and stays 1. A configuration write with bit 2 at 1 clears it, and a write with bit 2 at 0 leaves it unchanged. If a clearing write lands on the same edge as an expiry, the status stays 1.
- R9: err_pulse is high for exactly the cycle in which disc_valid is high, and only if cfg bit 1 (error enable) was 1 at expiry. Otherwise it stays low.
- R10: Configuration layout: bit 0 selects the short range, bit 1 enables the error pulse, and bit 2 is the status flag. A write loads bits 0 and 1 directly, while bit 2 cannot be set by software.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | A completion is at the head of the queue |
| head_id | input | ID_W | ID of the head completion |
| retry_hit | input | 1 | A master retry matching the head entry was seen this cycle |
| disc_valid | output | 1 | One-cycle discard request for the head entry |
| disc_id | output | ID_W | ID of the entry being discarded |
| err_pulse | output | 1 | One-cycle error toward the primary side |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration write data |
| cfg_rdata | output | 3 | Configuration and status read value |

## Verification
The bench builds the block with LONG_EXP=6 and SHORT_EXP=3, which gives expiry windows of 64 and 8 clocks. At these sizes, exact expiry edges in both ranges can be checked in a few dozen cycles, including the last retry edge that still saves an entry and the first one that does not. Shorter windows also make it practical to run many randomized trials with a random range, error enable, ID and retry offset. Directed cases cover a status clear colliding with an expiry, the gap between back-to-back discards and timer restarts.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
  localparam int CFG_W = 3;

  typedef struct packed {
    logic sts;
    logic err_en;
    logic short_sel;
  } dtd_cfg_t;
endpackage

// File: rtl/dtd_cfg_regs.sv
module dtd_cfg_regs
  import dtd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             set_sts,
  output dtd_cfg_t         cfg
);
  dtd_cfg_t cfg_q;
  dtd_cfg_t wr_view;

  assign wr_view = dtd_cfg_t'(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (we) begin
        cfg_q.short_sel <= wr_view.short_sel;
        cfg_q.err_en    <= wr_view.err_en;
      end
      cfg_q.sts <= set_sts | (cfg_q.sts & ~(we & wr_view.sts));
    end
  end

  assign cfg = cfg_q;

  assert_sts_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_sts |=> cfg_q.sts);
  assert_sts_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.sts && !we) |=> cfg_q.sts);
endmodule

// File: rtl/dtd_head_timer.sv
module dtd_head_timer #(
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 10,
  parameter int ID_W      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            head_valid,
  input  logic [ID_W-1:0] head_id,
  input  logic            retry_hit,
  input  logic            short_sel,
  input  logic            blank,
  output logic            expire,
  output logic [ID_W-1:0] expire_id
);
  localparam int CNT_W = LONG_EXP + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << LONG_EXP;

  logic             trk_q, done_q;
  logic [ID_W-1:0]  trk_id_q;
  logic [CNT_W-1:0] cnt_q;
  logic             same_entry, limit_hit;

  assign same_entry = trk_q && (head_id == trk_id_q);
  assign limit_hit  = short_sel ? cnt_q[SHORT_EXP] : cnt_q[LONG_EXP];
  assign expire     = head_valid && !blank && same_entry && !done_q && limit_hit;
  assign expire_id  = trk_id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_q    <= 1'b0;
      done_q   <= 1'b0;
      trk_id_q <= '0;
      cnt_q    <= '0;
    end else if (blank || !head_valid || expire) begin
      trk_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!same_entry) begin
      trk_q    <= 1'b1;
      trk_id_q <= head_id;
      done_q   <= retry_hit;
      cnt_q    <= retry_hit ? '0 : CNT_W'(1);
    end else if (!done_q) begin
      if (retry_hit) begin
        done_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  always_comb begin
    assert_cnt_bound_R2: assert (!rst_n || cnt_q <= CNT_MAX);
  end

  assert_expire_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));
  assert_done_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && head_valid && !blank && head_id == trk_id_q) |=> (done_q && cnt_q == '0));
endmodule

// File: rtl/dtd_discard_out.sv
module dtd_discard_out #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            expire,
  input  logic [ID_W-1:0] expire_id,
  input  logic            err_en,
  output logic            disc_valid,
  output logic [ID_W-1:0] disc_id,
  output logic            err_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disc_valid <= 1'b0;
      disc_id    <= '0;
      err_pulse  <= 1'b0;
    end else begin
      disc_valid <= expire;
      err_pulse  <= expire & err_en;
      if (expire) disc_id <= expire_id;
    end
  end

  assert_disc_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disc_valid |=> !disc_valid);
  assert_err_with_disc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> disc_valid);
endmodule

// File: rtl/dtd_discard_timer.sv
module dtd_discard_timer
  import dtd_pkg::*;
#(
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 10,
  parameter int ID_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_valid,
  input  logic [ID_W-1:0]  head_id,
  input  logic             retry_hit,
  output logic             disc_valid,
  output logic [ID_W-1:0]  disc_id,
  output logic             err_pulse,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata
);
  dtd_cfg_t        cfg;
  logic            expire;
  logic [ID_W-1:0] expire_id;

  dtd_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .set_sts (expire),
    .cfg     (cfg)
  );

  dtd_head_timer #(
    .LONG_EXP  (LONG_EXP),
    .SHORT_EXP (SHORT_EXP),
    .ID_W      (ID_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (head_valid),
    .head_id    (head_id),
    .retry_hit  (retry_hit),
    .short_sel  (cfg.short_sel),
    .blank      (disc_valid),
    .expire     (expire),
    .expire_id  (expire_id)
  );

  dtd_discard_out #(.ID_W(ID_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .expire_id  (expire_id),
    .err_en     (cfg.err_en),
    .disc_valid (disc_valid),
    .disc_id    (disc_id),
    .err_pulse  (err_pulse)
  );

  assign cfg_rdata = CFG_W'(cfg);

  assert_sts_rise_with_disc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[2]) |-> disc_valid);
  assert_disc_needs_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disc_valid |-> $past(head_valid));
endmodule

// File: tb/dtd_discard_timer_bench.sv
module dtd_discard_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L_EXP = 6;
  localparam int S_EXP = 3;
  localparam int ID_W  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            head_valid = 1'b0;
  logic [ID_W-1:0] head_id = '0;
  logic            retry_hit = 1'b0;
  logic            disc_valid, err_pulse;
  logic [ID_W-1:0] disc_id;
  logic            cfg_we = 1'b0;
  logic [2:0]      cfg_wdata = '0;
  logic [2:0]      cfg_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtd_discard_timer #(.LONG_EXP(L_EXP), .SHORT_EXP(S_EXP), .ID_W(ID_W)) u_dtd_discard_timer (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_id(head_id),
    .retry_hit(retry_hit), .disc_valid(disc_valid), .disc_id(disc_id),
    .err_pulse(err_pulse), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  function automatic int win(input bit sel);
    return sel ? (1 << S_EXP) : (1 << L_EXP);
  endfunction

  function automatic bit discards(input bit sel, input int retry_at);
    return !(retry_at >= 1 && retry_at <= win(sel));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    head_valid = 1'b0; retry_hit = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic trial(input bit sel, input bit en, input logic [ID_W-1:0] id,
                       input int retry_at, input string tag);
    int first, pulses, errs, limit;
    logic [ID_W-1:0] got;
    bit exp_d;
    cfg_write({1'b1, en, sel});
    limit = win(sel) + 3; first = 0; pulses = 0; errs = 0; got = '0;
    head_valid = 1'b1; head_id = id;
    for (int n = 1; n <= limit; n++) begin
      retry_hit = (n == retry_at);
      @(negedge clk);
      if (disc_valid) begin
        pulses++;
        if (first == 0) begin first = n; got = disc_id; end
      end
      if (err_pulse) errs++;
    end
    retry_hit = 1'b0;
    exp_d = discards(sel, retry_at);
    if (exp_d) begin
      chk(first == win(sel) + 1, {tag, " expiry edge"}, first, win(sel) + 1);
      chk(got == id, {tag, " R6 disc_id"}, int'(got), int'(id));
      chk(pulses == 1, {tag, " R6 pulse count"}, pulses, 1);
      chk(errs == (en ? 1 : 0), {tag, " R9 err count"}, errs, en ? 1 : 0);
      chk(cfg_rdata[2] == 1'b1, {tag, " R8 status set"}, int'(cfg_rdata[2]), 1);
    end else begin
      chk(pulses == 0, {tag, " R4 no discard"}, pulses, 0);
      chk(errs == 0, {tag, " R9 no err"}, errs, 0);
      chk(cfg_rdata[2] == 1'b0, {tag, " R8 status clear"}, int'(cfg_rdata[2]), 0);
    end
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int first, second, cnt;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 3'b000, "R1 cfg_rdata", int'(cfg_rdata), 0);
    chk(disc_valid == 1'b0, "R1 disc_valid", int'(disc_valid), 0);
    chk(err_pulse == 1'b0, "R1 err_pulse", int'(err_pulse), 0);

    // R10 layout, status not settable by software
    cfg_write(3'b111);
    chk(cfg_rdata == 3'b011, "R10 layout write", int'(cfg_rdata), 3);
    cfg_write(3'b000);
    chk(cfg_rdata == 3'b000, "R10 layout clear", int'(cfg_rdata), 0);

    trial(1'b0, 1'b0, 4'h3, 0, "R2 long");
    trial(1'b1, 1'b1, 4'hA, 0, "R3 short");
    trial(1'b1, 1'b1, 4'h1, 1, "R4 retry first edge");
    trial(1'b1, 1'b0, 4'h2, win(1'b1), "R4 retry last edge");
    trial(1'b1, 1'b1, 4'h4, win(1'b1) + 1, "R5 retry on expiry edge");
    trial(1'b0, 1'b1, 4'h5, win(1'b0), "R4 long last edge");
    trial(1'b0, 1'b1, 4'h6, win(1'b0) + 1, "R5 long expiry edge");

    // R8: status survives write of 0, cleared by write of 1
    trial(1'b1, 1'b0, 4'h7, 0, "R8 prep");
    cfg_write(3'b001);
    chk(cfg_rdata[2] == 1'b1, "R8 write0 keeps", int'(cfg_rdata[2]), 1);
    cfg_write(3'b101);
    chk(cfg_rdata[2] == 1'b0, "R8 write1 clears", int'(cfg_rdata[2]), 0);

    // R8: clear on the expiry edge loses to the set
    head_valid = 1'b1; head_id = 4'h9;
    for (int n = 1; n <= win(1'b1) + 1; n++) begin
      if (n == win(1'b1) + 1) begin cfg_we = 1'b1; cfg_wdata = 3'b101; end
      @(negedge clk);
    end
    cfg_we = 1'b0;
    chk(disc_valid == 1'b1, "R8 collide disc", int'(disc_valid), 1);
    chk(cfg_rdata[2] == 1'b1, "R8 set wins over clear", int'(cfg_rdata[2]), 1);
    idle(2);
    cfg_write(3'b101);

    // R6 gap between discards of a held head
    first = 0; second = 0; cnt = 0;
    head_valid = 1'b1; head_id = 4'hC;
    for (int n = 1; n <= 2 * win(1'b1) + 4; n++) begin
      @(negedge clk);
      if (disc_valid) begin
        cnt++;
        if (first == 0) first = n; else if (second == 0) second = n;
      end
    end
    chk(first == win(1'b1) + 1, "R6 first discard", first, win(1'b1) + 1);
    chk(second == 2 * win(1'b1) + 3, "R6 re-arm discard", second, 2 * win(1'b1) + 3);
    idle(2);

    // R7 ID change restarts
    first = 0;
    head_valid = 1'b1; head_id = 4'h2;
    for (int n = 1; n <= 5 + win(1'b1) + 2; n++) begin
      if (n == 6) head_id = 4'h3;
      @(negedge clk);
      if (disc_valid && first == 0) begin
        first = n;
        chk(disc_id == 4'h3, "R7 new id discarded", int'(disc_id), 3);
      end
    end
    chk(first == 5 + win(1'b1) + 1, "R7 id change edge", first, 5 + win(1'b1) + 1);
    idle(2);

    // R7 valid drop restarts
    first = 0;
    for (int n = 1; n <= 7 + win(1'b1) + 2; n++) begin
      head_valid = !(n == 6 || n == 7); head_id = 4'h8;
      @(negedge clk);
      if (disc_valid && first == 0) first = n;
    end
    chk(first == 7 + win(1'b1) + 1, "R7 valid drop edge", first, 7 + win(1'b1) + 1);
    idle(2);

    // random trials
    for (int t = 0; t < 24; t++) begin
      bit sel, en;
      int r;
      logic [ID_W-1:0] id;
      sel = ($urandom % 4) != 0;
      en = $urandom % 2;
      id = ID_W'($urandom);
      r = ($urandom % 3 == 0) ? 0 : int'($urandom % (win(sel) + 3));
      trial(sel, en, id, r, discards(sel, r) ? "R2 R3 random expiry" : "R4 random retry");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule